// File: doc/BRIEF.md
# I2C EEPROM Slave Controller

This block is the bus-facing half of a byte-wide serial memory. It watches an oversampled two-wire bus on the system clock and recognises bus framing. It answers only to the device byte whose upper nibble is 1010 and whose select bits equal three strap inputs. After a two-byte word address it moves data between the bus and an external memory port, one byte per transfer. The memory port has a combinational read and a one-cycle write strobe.

The serial data line is driven only as an open-drain pull-down enable. A write-protect input suppresses every memory update. After each write session a programmable busy timer stands in for the nonvolatile programming time. While that timer runs, the device byte is not acknowledged.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: While SCL is high, a falling SDA is taken as a START and a rising SDA as a STOP. Bits clocked before the first START never cause the slave to pull SDA low.
- R2: A device byte `{4'b1010, dev_sel_i, rw}` is acknowledged by pulling SDA low in the 9th clock. Any other device byte gets no acknowledge, and the slave ignores the bus until the next START.
- R3: In write mode both word-address bytes and every data byte are acknowledged. Each data byte gives one single-cycle `mem_we_o` pulse at the current pointer with the received byte on `mem_wdata_o`.
- R4: The word address is sent high byte first, as `{high[ADDR_W-9:0], low}`; higher bits of the high byte are ignored. The pointer advances by one after every byte transferred and wraps from the last location to 0.
- R5: In read mode, bytes are shifted out MSB first from the pointer location. The next byte follows only if the master pulled SDA low in the 9th clock. After a master NoACK the slave keeps SDA released until a new START.
- R6: A read issued right after the device byte, with no address phase, continues from the current pointer.
- R7: While `wp_i` is high, data bytes are still acknowledged, but `mem_we_o` stays low, the array keeps its content, and no busy cycle follows.
- R8: A STOP that ends a session with at least one performed write raises `busy_o` for exactly WR_CYCLES clock cycles. While `busy_o` is high, a matching device byte is not acknowledged and no write occurs.
- R9: Input bits are sampled on the rising SCL edge. The SDA pull-down enable is only ever asserted while SCL is low, after a falling SCL edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8 times the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| dev_sel_i | input | 3 | Strapped device select bits |
| wp_i | input | 1 | Write protect, high blocks memory updates |
| mem_addr_o | output | ADDR_W | Memory word address (pointer) |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Single-cycle write strobe |
| mem_rdata_i | input | 8 | Read data for `mem_addr_o`, combinational |
| busy_o | output | 1 | Write-cycle timer running |

## Verification
On every cycle the checker ensures the following. The write strobe is a single-cycle pulse and never follows a cycle with write protect high. No write strobe occurs while the busy timer runs, and the busy run never exceeds WR_CYCLES. The pull-down enable only rises while SCL is low.

Other properties need whole bus transactions, so only the bench scenarios can show them. These are device-byte matching (swept over all 128 write-mode address bytes), address wrap and the ignored high-address bits. They also include the master-driven read continuation, current-address reads, the exact busy duration and read-back after protected and unprotected writes.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RDAT_ACK
  } eep_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
        prev_q <= 1'b1;
      end else begin
        meta_q <= line_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign cur_o[g]  = sync_q;
    assign prev_o[g] = prev_q;
  end
endmodule

// File: rtl/i2c_busy_timer.sv
module i2c_busy_timer #(
  parameter int CYCLES = 625000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_eep_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int WR_CYCLES = 625000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        dev_sel_i,
  input  logic              wp_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              busy_o
);
  localparam int HI_W = ADDR_W - 8;

  logic [1:0] line_cur, line_prev;
  logic scl_s, sda_s, scl_p, sda_p;
  logic scl_rise, scl_fall, bus_start, bus_stop;

  i2c_line_sync #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i ({scl_i, sda_i}),
    .cur_o  (line_cur),
    .prev_o (line_prev)
  );

  assign scl_s     = line_cur[1];
  assign sda_s     = line_cur[0];
  assign scl_p     = line_prev[1];
  assign sda_p     = line_prev[0];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

  eep_state_e        state_q;
  logic [3:0]        bit_cnt_q;
  logic [7:0]        rx_sr_q, tx_sr_q, wdata_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              oe_q, rw_q, mack_q, wr_pend_q, we_q, inc_q, tmr_start_q;

  logic in_rx, rx_take, rx_done, dev_match;

  assign in_rx   = (state_q == ST_DEV) || (state_q == ST_AHI) ||
                   (state_q == ST_ALO) || (state_q == ST_WDAT);
  assign rx_take = in_rx && scl_rise && (bit_cnt_q != 4'd8);
  assign rx_done = in_rx && scl_fall && (bit_cnt_q == 4'd8);
  assign dev_match = (rx_sr_q[7:4] == DEV_CODE) && (rx_sr_q[3:1] == dev_sel_i) && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      rx_sr_q     <= '0;
      tx_sr_q     <= '0;
      wdata_q     <= '0;
      ptr_q       <= '0;
      oe_q        <= 1'b0;
      rw_q        <= 1'b0;
      mack_q      <= 1'b0;
      wr_pend_q   <= 1'b0;
      we_q        <= 1'b0;
      inc_q       <= 1'b0;
      tmr_start_q <= 1'b0;
    end else begin
      we_q        <= 1'b0;
      inc_q       <= 1'b0;
      tmr_start_q <= 1'b0;
      if (inc_q) ptr_q <= ptr_q + 1'b1;
      if (we_q)  wr_pend_q <= 1'b1;

      if (bus_stop) begin
        state_q     <= ST_IDLE;
        oe_q        <= 1'b0;
        tmr_start_q <= wr_pend_q;
        wr_pend_q   <= 1'b0;
      end else if (bus_start) begin
        state_q   <= ST_DEV;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else begin
        if (rx_take) begin
          rx_sr_q   <= {rx_sr_q[6:0], sda_s};
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
        unique case (state_q)
          ST_DEV: if (rx_done) begin
            bit_cnt_q <= '0;
            if (dev_match) begin
              oe_q    <= 1'b1;
              rw_q    <= rx_sr_q[0];
              state_q <= ST_DEV_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_AHI: if (rx_done) begin
            bit_cnt_q          <= '0;
            ptr_q[ADDR_W-1:8]  <= rx_sr_q[HI_W-1:0];
            oe_q               <= 1'b1;
            state_q            <= ST_AHI_ACK;
          end
          ST_ALO: if (rx_done) begin
            bit_cnt_q   <= '0;
            ptr_q[7:0]  <= rx_sr_q;
            oe_q        <= 1'b1;
            state_q     <= ST_ALO_ACK;
          end
          ST_WDAT: if (rx_done) begin
            bit_cnt_q <= '0;
            we_q      <= ~wp_i;
            inc_q     <= 1'b1;
            wdata_q   <= rx_sr_q;
            oe_q      <= 1'b1;
            state_q   <= ST_WDAT_ACK;
          end
          ST_DEV_ACK: if (scl_fall) begin
            bit_cnt_q <= '0;
            if (rw_q) begin
              tx_sr_q <= mem_rdata_i;
              oe_q    <= ~mem_rdata_i[7];
              state_q <= ST_RDAT;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_AHI;
            end
          end
          ST_AHI_ACK: if (scl_fall) begin
            bit_cnt_q <= '0;
            oe_q      <= 1'b0;
            state_q   <= ST_ALO;
          end
          ST_ALO_ACK, ST_WDAT_ACK: if (scl_fall) begin
            bit_cnt_q <= '0;
            oe_q      <= 1'b0;
            state_q   <= ST_WDAT;
          end
          ST_RDAT: if (scl_fall) begin
            if (bit_cnt_q == 4'd7) begin
              oe_q    <= 1'b0;
              inc_q   <= 1'b1;
              mack_q  <= 1'b0;
              state_q <= ST_RDAT_ACK;
            end else begin
              tx_sr_q   <= {tx_sr_q[6:0], 1'b0};
              oe_q      <= ~tx_sr_q[6];
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
          ST_RDAT_ACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            if (scl_fall) begin
              if (mack_q) begin
                tx_sr_q   <= mem_rdata_i;
                oe_q      <= ~mem_rdata_i[7];
                bit_cnt_q <= '0;
                state_q   <= ST_RDAT;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  i2c_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start_q),
    .busy_o  (busy_o)
  );

  assign sda_oe_o    = oe_q;
  assign mem_addr_o  = ptr_q;
  assign mem_wdata_o = wdata_q;
  assign mem_we_o    = we_q;
endmodule

// File: rtl/i2c_eep_chk.sv
module i2c_eep_chk #(
  parameter int WR_CYCLES = 625000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic wp_i,
  input logic sda_oe_o,
  input logic mem_we_o,
  input logic busy_o
);
  localparam int RUN_W = $clog2(WR_CYCLES + 2);

  logic [RUN_W-1:0] busy_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_run_q <= '0;
    else if (busy_o) busy_run_q <= busy_run_q + 1'b1;
    else             busy_run_q <= '0;
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i); // R9
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o); // R3
  AST_WE_NOT_WP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !$past(wp_i)); // R7
  AST_BUSY_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !mem_we_o); // R8
  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run_q <= RUN_W'(WR_CYCLES)); // R8
endmodule

bind i2c_eeprom_slave i2c_eep_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .wp_i     (wp_i),
  .sda_oe_o (sda_oe_o),
  .mem_we_o (mem_we_o),
  .busy_o   (busy_o)
);

// File: tb/i2c_eeprom_slave_tb_top.sv
module i2c_eeprom_slave_tb_top;
  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;
  localparam int WRC   = 300;
  localparam logic [2:0] PINS = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe, mem_we, busy;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic sda_bus;

  logic [7:0] mem [DEPTH];
  logic [7:0] exp_mem [DEPTH];

  int n_cmp = 0;
  int n_bad = 0;
  int oe_cycles = 0;
  int busy_run = 0;
  int last_run = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign sda_bus   = sda_m & ~sda_oe;
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (sda_oe) oe_cycles <= oe_cycles + 1;
    if (busy) busy_run <= busy_run + 1;
    else if (busy_run != 0) begin
      last_run <= busy_run;
      busy_run <= 0;
    end
  end

  i2c_eeprom_slave #(.ADDR_W(AW), .WR_CYCLES(WRC)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .dev_sel_i   (PINS),
    .wp_i        (wp),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .mem_rdata_i (mem_rdata),
    .busy_o      (busy)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(8);
    sda_m = 1'b0; tick(8);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    tick(4); sda_m = 1'b0; tick(4);
    scl_m = 1'b1; tick(8);
    sda_m = 1'b1; tick(8);
  endtask

  task automatic send_bit(input logic b);
    tick(4); sda_m = b; tick(4);
    scl_m = 1'b1; tick(8);
    scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    tick(4); sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(4);
    b = sda_bus; tick(4);
    scl_m = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    send_bit(~mack);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5 * WRC) begin
      tick(1);
      n++;
    end
    tick(4);
  endtask

  function automatic logic [7:0] dev_byte(input logic rd);
    return {4'b1010, PINS, rd};
  endfunction

  initial begin : watchdog
    tick(150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic ack;
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]     = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    tick(3);
    rst_n = 1'b1;
    tick(3);
    // R1: reset state
    check("R1 reset oe", int'(sda_oe), 0);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset we", int'(mem_we), 0);

    // R1: matching byte clocked with no START
    scl_m = 1'b0; tick(4);
    oe_cycles = 0;
    wr_byte(dev_byte(1'b0), ack);
    check("R1 no-start ack", int'(ack), 0);
    for (int i = 0; i < 9; i++) send_bit(1'b0);
    check("R1 no-start drive cycles", oe_cycles, 0);
    bus_stop();

    // R2: sweep of every write-mode device byte
    for (int a = 0; a < 128; a++) begin
      bus_start();
      wr_byte({7'(a), 1'b0}, ack);
      check($sformatf("R2 dev %02h", a), int'(ack),
            int'((a[6:3] == 4'b1010) && (a[2:0] == PINS)));
      bus_stop();
    end

    // R3 R4: write 4 bytes at top of array, high byte upper bits set
    bus_start();
    wr_byte(dev_byte(1'b0), ack); check("R3 dev ack", int'(ack), 1);
    wr_byte(8'hFF, ack);          check("R3 addr hi ack", int'(ack), 1);
    wr_byte(8'hFE, ack);          check("R3 addr lo ack", int'(ack), 1);
    for (int i = 0; i < 4; i++) begin
      v = 8'hA1 + 8'(i * 17);
      wr_byte(v, ack);
      check("R3 data ack", int'(ack), 1);
      exp_mem[(AW'(9'h1FE) + AW'(i)) % DEPTH] = v;
    end
    bus_stop();
    tick(8);
    check("R8 busy after write", int'(busy), 1);
    bus_start();
    wr_byte(dev_byte(1'b0), ack);
    check("R8 nack while busy", int'(ack), 0);
    bus_stop();
    wait_idle();
    check("R8 busy length", last_run, WRC);

    // R5 R4: random read across the wrap point
    bus_start();
    wr_byte(dev_byte(1'b0), ack);
    wr_byte(8'h01, ack);
    wr_byte(8'hFE, ack);
    bus_start();
    wr_byte(dev_byte(1'b1), ack);
    check("R5 read dev ack", int'(ack), 1);
    for (int i = 0; i < 5; i++) begin
      rd_byte(i != 4, v);
      check($sformatf("R4 R5 read byte %0d", i), int'(v),
            int'(exp_mem[(9'h1FE + i) % DEPTH]));
    end
    // R5: released after NoACK, no STOP yet
    oe_cycles = 0;
    for (int i = 0; i < 9; i++) send_bit(1'b1);
    check("R5 released after noack", oe_cycles, 0);
    bus_stop();

    // R6: current-address read continues at 0x003
    bus_start();
    wr_byte(dev_byte(1'b1), ack);
    check("R6 dev ack", int'(ack), 1);
    rd_byte(1'b1, v); check("R6 byte 0", int'(v), int'(exp_mem[3]));
    rd_byte(1'b0, v); check("R6 byte 1", int'(v), int'(exp_mem[4]));
    bus_stop();

    // R7: protected write
    wp = 1'b1;
    bus_start();
    wr_byte(dev_byte(1'b0), ack);
    wr_byte(8'h00, ack);
    wr_byte(8'h40, ack);
    wr_byte(8'h55, ack); check("R7 data ack", int'(ack), 1);
    wr_byte(8'h66, ack);
    bus_stop();
    tick(8);
    check("R7 no busy", int'(busy), 0);
    wp = 1'b0;
    bus_start();
    wr_byte(dev_byte(1'b0), ack);
    wr_byte(8'h00, ack);
    wr_byte(8'h40, ack);
    bus_start();
    wr_byte(dev_byte(1'b1), ack);
    rd_byte(1'b1, v); check("R7 kept 0x40", int'(v), int'(exp_mem[9'h040]));
    rd_byte(1'b0, v); check("R7 kept 0x41", int'(v), int'(exp_mem[9'h041]));
    bus_stop();

    // R3: unprotected write and read back
    bus_start();
    wr_byte(dev_byte(1'b0), ack);
    wr_byte(8'h00, ack);
    wr_byte(8'h40, ack);
    wr_byte(8'h5A, ack); exp_mem[9'h040] = 8'h5A;
    wr_byte(8'hC3, ack); exp_mem[9'h041] = 8'hC3;
    bus_stop();
    wait_idle();
    bus_start();
    wr_byte(dev_byte(1'b0), ack);
    wr_byte(8'h00, ack);
    wr_byte(8'h40, ack);
    bus_start();
    wr_byte(dev_byte(1'b1), ack);
    rd_byte(1'b1, v); check("R3 readback 0x40", int'(v), 32'h5A);
    rd_byte(1'b0, v); check("R3 readback 0x41", int'(v), 32'hC3);
    bus_stop();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule